// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM that holds 1M words of 16 bits. The host asks for one word at a time: it presents an address, write data, a per-byte lane select and a direction, then pulses a request. The block turns that into a timed sequence on the RAM pins and reports completion with a one-cycle done pulse. On reads it also presents the captured word.

The RAM pins are a 20-bit address, a low-active chip select paired with a high-active chip select, low-active write and output strobes, one low-active strobe per byte lane, and a shared tri-state data bus. Every phase length is derived from nanosecond-level timing parameters, given in picoseconds, and the clock period. Each count is rounded up and is never less than one cycle. The defaults match the fast grade, and the slower grade is reached by overriding the parameters. The sequence keeps every strobe inactive while the address moves. It holds the output strobe high through the whole write, and it only drives data once the RAM has released the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the memory pins are inactive: `mem_ce_n_o`=1, `mem_ce2_o`=0, `mem_we_n_o`=1, `mem_oe_n_o`=1 and both lane strobes are 1. `busy_o`, `done_o` and `rdata_o` are 0 after reset.
- R2: A write stores `req_wdata_i` at `req_addr_i`, but only in the selected lanes. Bit 0 of `req_sel_i` selects data bits 7:0 (strobe `mem_bl_n_o[0]`) and bit 1 selects bits 15:8 (strobe `mem_bl_n_o[1]`). A lane that is not selected keeps its old contents.
- R3: A read returns the selected lanes on `rdata_o`, and any lane that is not selected reads as zero. `rdata_o` holds its value until the next read captures a new one.
- R4: With default parameters and an 8 ns clock, `done_o` is first seen high 4 cycles after the accepting clock edge for a read, and 3 cycles after it for a write.
- R5: `done_o` is high for exactly one cycle per request.
- R6: A request that arrives while `busy_o` is high is ignored. It does not alter the access in flight, and it does not start another one.
- R7: A request with `req_sel_i`=0 completes with a done pulse on the next cycle. It asserts no chip select or strobe, and it changes no memory contents.
- R8: `mem_addr_o` changes only in cycles that follow a cycle in which chip select, write strobe and both lane strobes were all inactive.
- R9: The write strobe is never low while the output strobe is low. The block's data driver turns on only after the output strobe has been high for at least the output-release count.
- R10: The two chip selects always move together: `mem_ce2_o` is the inverse of `mem_ce_n_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request pulse, taken when not busy |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_sel_i | input | 2 | Lane select, bit 0 = bits 7:0 |
| busy_o | output | 1 | Access in progress or done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read word |
| mem_addr_o | output | 20 | RAM address |
| mem_ce_n_o | output | 1 | Low-active chip select |
| mem_ce2_o | output | 1 | High-active chip select |
| mem_we_n_o | output | 1 | Low-active write strobe |
| mem_oe_n_o | output | 1 | Low-active output strobe |
| mem_bl_n_o | output | 2 | Low-active lane strobes |
| mem_dq_io | inout | 16 | Shared data bus |

## Verification
The bench goes after partial-lane writes and reads. A design that mapped the lanes wrong, or wrote every lane, would corrupt the neighbouring byte or return stale bytes where zeros are due. It changes the host data and fires a second request in the middle of a write. If the block re-sampled its inputs or accepted the request while busy, it would store the wrong word. It also sends an empty lane select, and it watches for any address move under active strobes or a write strobe that overlaps the output strobe. Both of those would corrupt a real RAM. Latency is checked cycle by cycle, which exposes a wrong rounding of the timing parameters.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RACC,
        ST_RREL,
        ST_WPUL,
        ST_WHOLD
    } st_e;

    // active-high internal control enables, mapped to pins at the top
    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
        logic lane;
        logic drive;
    } ctl_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // picoseconds to cycles, rounded up, at least one
    function automatic int unsigned ps2cyc(input int unsigned ps, input int unsigned clk_ps);
        int unsigned c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/asram_cnt.sv
module asram_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int unsigned CW    = 1,
    parameter int unsigned AS_C  = 1,
    parameter int unsigned RD_C  = 2,
    parameter int unsigned OHZ_C = 1,
    parameter int unsigned WP_C  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_wr,
    input  logic          cnt_zero,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output st_e           state,
    output ctl_t          ctl,
    output logic          cap,
    output logic          fin
);
    st_e state_n;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    always_comb begin
        state_n  = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cap      = 1'b0;
        fin      = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                state_n  = ST_ADDR;
                cnt_load = 1'b1;
                cnt_val  = CW'(AS_C - 1);
            end
            ST_ADDR: if (cnt_zero) begin
                cnt_load = 1'b1;
                if (start_wr) begin
                    state_n = ST_WPUL;
                    cnt_val = CW'(WP_C - 1);
                end else begin
                    state_n = ST_RACC;
                    cnt_val = CW'(RD_C - 1);
                end
            end
            ST_RACC: if (cnt_zero) begin
                cap      = 1'b1;
                state_n  = ST_RREL;
                cnt_load = 1'b1;
                cnt_val  = CW'(OHZ_C - 1);
            end
            ST_RREL: if (cnt_zero) begin
                state_n = ST_IDLE;
                fin     = 1'b1;
            end
            ST_WPUL: if (cnt_zero) begin
                state_n  = ST_WHOLD;
                cnt_load = 1'b1;
                cnt_val  = '0;
            end
            ST_WHOLD: if (cnt_zero) begin
                state_n = ST_IDLE;
                fin     = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RACC:  begin ctl.ce = 1'b1; ctl.oe = 1'b1; ctl.lane = 1'b1; end
            ST_WPUL:  begin ctl.ce = 1'b1; ctl.we = 1'b1; ctl.lane = 1'b1; ctl.drive = 1'b1; end
            ST_WHOLD: ctl.drive = 1'b1;
            default:  ctl = '0;
        endcase
    end

    // R9
    drv_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.drive |-> (!ctl.oe && !$past(ctl.oe)));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned T_CLK_PS = 8000,
    parameter int unsigned T_AS_PS  = 0,
    parameter int unsigned T_AA_PS  = 10000,
    parameter int unsigned T_OE_PS  = 4500,
    parameter int unsigned T_OHZ_PS = 4000,
    parameter int unsigned T_WP_PS  = 8000,
    parameter int unsigned T_DW_PS  = 6000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_i,
    input  logic                   req_wr_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    input  logic [DATA_W/8-1:0]    req_sel_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [ADDR_W-1:0]      mem_addr_o,
    output logic                   mem_ce_n_o,
    output logic                   mem_ce2_o,
    output logic                   mem_we_n_o,
    output logic                   mem_oe_n_o,
    output logic [DATA_W/8-1:0]    mem_bl_n_o,
    inout  wire  [DATA_W-1:0]      mem_dq_io
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned C_AS  = ps2cyc(T_AS_PS, T_CLK_PS);
    localparam int unsigned C_RD  = ps2cyc(umax(T_AA_PS, T_OE_PS), T_CLK_PS);
    localparam int unsigned C_OHZ = ps2cyc(T_OHZ_PS, T_CLK_PS);
    localparam int unsigned C_WP  = ps2cyc(umax(T_WP_PS, T_DW_PS), T_CLK_PS);
    localparam int unsigned C_MAX = umax(umax(C_AS, C_RD), umax(C_OHZ, C_WP));
    localparam int unsigned CW    = (C_MAX < 2) ? 1 : $clog2(C_MAX);

    typedef struct packed {
        logic              wr;
        logic [LANES-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_t;

    op_t           op_q;
    st_e           state;
    ctl_t          ctl;
    logic          cnt_load, cnt_zero, cap, fin, done_q;
    logic [CW-1:0] cnt_val;
    logic          accept, start, noop;

    assign accept = req_i && !busy_o;
    assign noop   = accept && (req_sel_i == '0);
    assign start  = accept && (req_sel_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept)
                op_q <= '{wr: req_wr_i, sel: req_sel_i, addr: req_addr_i, data: req_wdata_i};
            done_q <= fin | noop;
        end
    end

    asram_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    asram_fsm #(
        .CW(CW), .AS_C(C_AS), .RD_C(C_RD), .OHZ_C(C_OHZ), .WP_C(C_WP)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .start_wr(op_q.wr),
        .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .state(state), .ctl(ctl), .cap(cap), .fin(fin)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata_o[g*8 +: 8] <= '0;
            else if (cap)
                rdata_o[g*8 +: 8] <= op_q.sel[g] ? mem_dq_io[g*8 +: 8] : 8'h00;
        end
        assign mem_bl_n_o[g] = !(ctl.lane && op_q.sel[g]);
    end

    assign busy_o     = (state != ST_IDLE) || done_q;
    assign done_o     = done_q;
    assign mem_addr_o = op_q.addr;
    assign mem_ce_n_o = !ctl.ce;
    assign mem_ce2_o  = ctl.ce;
    assign mem_we_n_o = !ctl.we;
    assign mem_oe_n_o = !ctl.oe;
    assign mem_dq_io  = ctl.drive ? op_q.data : {DATA_W{1'bz}};

    // R9
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n_o |-> mem_oe_n_o);
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr_o) |-> $past(mem_ce_n_o && mem_we_n_o && (&mem_bl_n_o)));
    // R7
    strobe_noop_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n_o |-> !(&mem_bl_n_o));
    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(rdata_o));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, wr = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  sel = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic [19:0] m_addr;
    logic        ce_n, ce2, we_n, oe_n;
    logic [1:0]  bl_n;
    wire  [15:0] dq;

    int total = 0, bad = 0, cyc = 0, ce_low = 0;

    always #4 clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req), .req_wr_i(wr), .req_addr_i(addr),
        .req_wdata_i(wdata), .req_sel_i(sel), .busy_o(busy), .done_o(done),
        .rdata_o(rdata), .mem_addr_o(m_addr), .mem_ce_n_o(ce_n), .mem_ce2_o(ce2),
        .mem_we_n_o(we_n), .mem_oe_n_o(oe_n), .mem_bl_n_o(bl_n), .mem_dq_io(dq)
    );

    // RAM model, 256 words aliased on the low address bits
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    logic        rd_act;
    assign rd_act = !ce_n && ce2 && we_n && !oe_n;
    assign dq[7:0]  = (rd_act && !bl_n[0]) ? mem[m_addr[7:0]][7:0]  : 8'bz;
    assign dq[15:8] = (rd_act && !bl_n[1]) ? mem[m_addr[7:0]][15:8] : 8'bz;

    initial for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end

    always @(negedge clk) begin
        if (!ce_n && ce2 && !we_n) begin
            if (!bl_n[0]) mem[m_addr[7:0]][7:0]  <= dq[7:0];
            if (!bl_n[1]) mem[m_addr[7:0]][15:8] <= dq[15:8];
        end
    end

    // pin monitors
    logic [19:0] prev_addr;
    logic        prev_quiet;
    int          mon_bad = 0;
    always @(negedge clk) begin
        cyc++;
        if (!ce_n) ce_low++;
        if (!rst) begin
            if (m_addr != prev_addr && !prev_quiet) begin
                mon_bad++; $display("FAIL R8 addr moved %h->%h under active strobes", prev_addr, m_addr);
            end
            if (!we_n && !oe_n) begin
                mon_bad++; $display("FAIL R9 we_n=%b oe_n=%b expected not both 0", we_n, oe_n);
            end
            if (ce2 != !ce_n) begin
                mon_bad++; $display("FAIL R10 ce2=%b expected %b", ce2, !ce_n);
            end
        end
        prev_addr  = m_addr;
        prev_quiet = ce_n && we_n && (&bl_n);
    end

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic do_op(input logic w, input logic [1:0] s, input logic [19:0] a,
                         input logic [15:0] d, input bit inject,
                         output logic [15:0] rd, output int n);
        @(negedge clk);
        req = 1'b1; wr = w; sel = s; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (!done && n < 50) begin
            if (inject && n == 2) begin
                req = 1'b1; wr = 1'b1; sel = 2'b11; wdata = 16'hAAAA;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        rd = rdata;
        @(negedge clk);
        chk(!done, "R5 done single cycle", {31'b0, done}, 32'h0);
    endtask

    localparam logic [38:0] VEC [8] = '{
        {1'b1, 2'b11, 20'h00010, 16'hA5C3},
        {1'b0, 2'b11, 20'h00010, 16'h0000},
        {1'b1, 2'b01, 20'h00010, 16'h1177},
        {1'b0, 2'b10, 20'h00010, 16'h0000},
        {1'b1, 2'b10, 20'h00020, 16'hBEEF},
        {1'b0, 2'b01, 20'h00020, 16'h0000},
        {1'b1, 2'b11, 20'hFFFFF, 16'h1234},
        {1'b0, 2'b11, 20'hFFFFF, 16'h0000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd, expv, sh;
        int n, ce0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ce_n && !ce2 && we_n && oe_n && bl_n == 2'b11, "R1 pins idle",
            {26'b0, ce_n, ce2, we_n, oe_n, bl_n}, {26'b0, 6'b101111});
        chk(!busy && !done && rdata == 16'h0, "R1 host outputs",
            {14'b0, busy, done, rdata}, 32'h0);

        for (int i = 0; i < 8; i++) begin
            logic        vw;
            logic [1:0]  vs;
            logic [19:0] va;
            logic [15:0] vd;
            {vw, vs, va, vd} = VEC[i];
            do_op(vw, vs, va, vd, 1'b0, rd, n);
            sh = shadow[va[7:0]];
            if (vw) begin
                if (vs[0]) sh[7:0]  = vd[7:0];
                if (vs[1]) sh[15:8] = vd[15:8];
                shadow[va[7:0]] = sh;
                chk(n == 4, "R4 write latency", n, 4);
            end else begin
                expv = {vs[1] ? sh[15:8] : 8'h00, vs[0] ? sh[7:0] : 8'h00};
                chk(n == 5, "R4 read latency", n, 5);
                chk(rd == expv, vs == 2'b11 ? "R2 write/readback" : "R3 lane read", rd, expv);
            end
            chk(ce_n && !ce2 && we_n && oe_n && bl_n == 2'b11, "R1 pins idle after op",
                {26'b0, ce_n, ce2, we_n, oe_n, bl_n}, {26'b0, 6'b101111});
        end

        // R3 rdata held across a write
        do_op(1'b1, 2'b11, 20'h00040, 16'h7E7E, 1'b0, rd, n);
        chk(rdata == 16'h1234, "R3 rdata held", rdata, 16'h1234);

        // R6 request during busy ignored, host data changed mid-write
        do_op(1'b1, 2'b11, 20'h00030, 16'h5555, 1'b1, rd, n);
        chk(n == 4, "R6 latency unchanged", n, 4);
        @(negedge clk);
        chk(!busy && !done, "R6 no extra access", {30'b0, busy, done}, 32'h0);
        do_op(1'b0, 2'b11, 20'h00030, 16'h0000, 1'b0, rd, n);
        chk(rd == 16'h5555, "R6 stored word", rd, 16'h5555);

        // R7 empty lane select
        ce0 = ce_low;
        do_op(1'b1, 2'b00, 20'h00030, 16'h0000, 1'b0, rd, n);
        chk(n == 1, "R7 noop done next cycle", n, 1);
        chk(ce_low == ce0, "R7 no strobes", ce_low - ce0, 0);
        do_op(1'b0, 2'b11, 20'h00030, 16'h0000, 1'b0, rd, n);
        chk(rd == 16'h5555, "R7 memory unchanged", rd, 16'h5555);

        // R8 R9 R10 pin monitors
        chk(mon_bad == 0, "R8 R9 R10 pin monitors", mon_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule